// File: doc/BRIEF.md
# Two-Wire Serial Bus Monitor

This block listens to the clock and data wires of a two-wire serial bus and turns what it sees into a stream of decoded events. It never drives either wire. Both lines are oversampled on a fast system clock. Each line passes through a short synchroniser, and a level change is recognised by comparing each sample with the one before it.

The decoder tracks three phases: waiting for a start, collecting the address byte, and collecting data bytes. It reports the following events:
- a start condition, or a repeated start;
- the address byte, with its transfer direction;
- each data byte, tagged with the latched direction;
- the acknowledge bit that follows every byte;
- a stop condition.

Each event is a one-cycle valid pulse that carries a 4-bit kind code and an 8-bit value. A host-side logger or checker consumes the stream. Because the output carries at most one event per cycle, such a consumer needs no arbitration.

Top module: `twi_bus_monitor`

## Requirements
- R1: While reset is high and for the warm-up cycles after it, no event is produced. A data line held low with the clock line held high through reset and then released high produces no event, and the block stays waiting for a start.
- R2: While waiting for a start, a fall of the data line (1 then 0 in consecutive samples) with the clock line high produces an event of kind 0 (START) with value 0x00, and the block moves to address collection.
- R3: Bits are taken only on a rise of the clock line (previous sample 0, current sample 1), most significant bit first. After 8 bits and a ninth acknowledge bit, an address event is emitted. Its value is the byte with bit 0 cleared. Its kind is 2 (address-write) when bit 0 is 0 and 3 (address-read) when bit 0 is 1.
- R4: The ninth bit of every byte produces a second event exactly one cycle after the byte event. This event has kind 6 (ACK) when the bit is 0, kind 7 (NACK) when the bit is 1, and value 0x00.
- R5: Every byte that follows the address byte is reported in full. Its kind is 4 (data-write) when the latched direction bit is 0 and 5 (data-read) when it is 1.
- R6: A start condition seen during data collection, with no stop since the previous start, produces kind 1 (repeated START) with value 0x00. It restarts address collection, clears the direction and clears the bit count.
- R7: A stop condition (a rise of the data line with the clock line high) during data collection produces kind 8 (STOP) with value 0x00 and returns to waiting for a start. The next start after a stop is reported as kind 0.
- R8: While waiting for a start, clock-line rises and stop conditions produce no events.
- R9: During address collection, start and stop conditions are ignored, and clock-line rises that occur while forming them are counted as bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| evt_valid | output | 1 | One-cycle pulse marking an event |
| evt_kind | output | 4 | Event kind code (0 to 8, see requirements) |
| evt_value | output | 8 | Byte value for address and data events, else 0 |

## Verification
On every cycle, the assertions check four things: that each byte event is followed directly by an ACK or NACK event, that an acknowledge event never appears without a byte event before it, that address values always have bit 0 clear, and that kind codes stay within range. The bench scenarios are the only place where the order of phases becomes visible. They show repeated start against first start, start and stop being ignored during address collection, quiet behaviour while waiting for a start, and the value and direction tag of each byte.

// File: rtl/twi_mon_pkg.sv
package twi_mon_pkg;

  typedef enum logic [3:0] {
    EV_START  = 4'd0,
    EV_RSTART = 4'd1,
    EV_ADDR_W = 4'd2,
    EV_ADDR_R = 4'd3,
    EV_DATA_W = 4'd4,
    EV_DATA_R = 4'd5,
    EV_ACK    = 4'd6,
    EV_NACK   = 4'd7,
    EV_STOP   = 4'd8
  } evt_kind_e;

  typedef enum logic [1:0] {
    PH_SEEK_START = 2'd0,
    PH_SEEK_ADDR  = 2'd1,
    PH_SEEK_DATA  = 2'd2
  } phase_e;

endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_now,
  output logic scl_rise,
  output logic start_cond,
  output logic stop_cond
);
  localparam int WARM  = SYNC_STAGES + 1;
  localparam int WCNTW = $clog2(WARM + 1);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;
  logic [WCNTW-1:0] warm_cnt;
  logic primed;
  logic scl_now;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_now = scl_pipe[SYNC_STAGES-1];
  assign sda_now = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
      warm_cnt <= '0;
    end else begin
      scl_prev <= scl_now;
      sda_prev <= sda_now;
      if (!primed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  assign primed     = (warm_cnt == WCNTW'(WARM));
  assign scl_rise   = primed && !scl_prev && scl_now;
  assign start_cond = primed && sda_prev && !sda_now && scl_now;
  assign stop_cond  = primed && !sda_prev && sda_now && scl_now;

endmodule

// File: rtl/twi_decoder.sv
module twi_decoder
  import twi_mon_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_now,
  input  logic              scl_rise,
  input  logic              start_cond,
  input  logic              stop_cond,
  output logic              evt_valid,
  output logic [3:0]        evt_kind,
  output logic [BYTE_W-1:0] evt_value
);
  localparam int CNT_W = $clog2(BYTE_W + 2);

  phase_e              phase;
  logic [CNT_W-1:0]    bit_cnt;
  logic [BYTE_W-1:0]   shreg;
  logic                dir_rd;
  logic                txn_open;
  logic                ack_pend;
  logic                ack_bit;

  logic take_bit, take_start, take_stop, last_bit;

  assign take_bit   = scl_rise && (phase != PH_SEEK_START);
  assign take_start = start_cond && !scl_rise &&
                      (phase == PH_SEEK_START || phase == PH_SEEK_DATA);
  assign take_stop  = stop_cond && !scl_rise && (phase == PH_SEEK_DATA);
  assign last_bit   = take_bit && (bit_cnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_SEEK_START;
      bit_cnt   <= '0;
      shreg     <= '0;
      dir_rd    <= 1'b0;
      txn_open  <= 1'b0;
      ack_pend  <= 1'b0;
      ack_bit   <= 1'b0;
      evt_valid <= 1'b0;
      evt_kind  <= EV_START;
      evt_value <= '0;
    end else begin
      evt_valid <= 1'b0;
      evt_kind  <= EV_START;
      evt_value <= '0;
      ack_pend  <= 1'b0;

      if (ack_pend) begin
        evt_valid <= 1'b1;
        evt_kind  <= ack_bit ? EV_NACK : EV_ACK;
      end

      if (last_bit) begin
        ack_pend  <= 1'b1;
        ack_bit   <= sda_now;
        bit_cnt   <= '0;
        shreg     <= '0;
        evt_valid <= 1'b1;
        if (phase == PH_SEEK_ADDR) begin
          dir_rd    <= shreg[0];
          evt_kind  <= shreg[0] ? EV_ADDR_R : EV_ADDR_W;
          evt_value <= {shreg[BYTE_W-1:1], 1'b0};
          phase     <= PH_SEEK_DATA;
        end else begin
          evt_kind  <= dir_rd ? EV_DATA_R : EV_DATA_W;
          evt_value <= shreg;
        end
      end else if (take_bit) begin
        shreg   <= {shreg[BYTE_W-2:0], sda_now};
        bit_cnt <= bit_cnt + 1'b1;
      end else if (take_start) begin
        evt_valid <= 1'b1;
        evt_kind  <= txn_open ? EV_RSTART : EV_START;
        txn_open  <= 1'b1;
        bit_cnt   <= '0;
        shreg     <= '0;
        dir_rd    <= 1'b0;
        phase     <= PH_SEEK_ADDR;
      end else if (take_stop) begin
        evt_valid <= 1'b1;
        evt_kind  <= EV_STOP;
        txn_open  <= 1'b0;
        dir_rd    <= 1'b0;
        phase     <= PH_SEEK_START;
      end
    end
  end

  // R4
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind >= EV_ADDR_W && evt_kind <= EV_DATA_R)
    |=> (evt_valid && (evt_kind == EV_ACK || evt_kind == EV_NACK)));

  // R4
  ack_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (evt_kind == EV_ACK || evt_kind == EV_NACK))
    |-> $past(evt_valid && evt_kind >= EV_ADDR_W && evt_kind <= EV_DATA_R));

  // R3
  addr_lsb_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (evt_kind == EV_ADDR_W || evt_kind == EV_ADDR_R))
    |-> !evt_value[0]);

  // R2
  kind_range_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt_kind <= EV_STOP));

endmodule

// File: rtl/twi_bus_monitor.sv
module twi_bus_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              evt_valid,
  output logic [3:0]        evt_kind,
  output logic [BYTE_W-1:0] evt_value
);
  logic sda_now, scl_rise, start_cond, stop_cond;

  twi_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_now(sda_now), .scl_rise(scl_rise),
    .start_cond(start_cond), .stop_cond(stop_cond)
  );

  twi_decoder #(.BYTE_W(BYTE_W)) u_dec (
    .clk(clk), .rst(rst), .sda_now(sda_now), .scl_rise(scl_rise),
    .start_cond(start_cond), .stop_cond(stop_cond),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_value(evt_value)
  );

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !evt_valid);

endmodule

// File: tb/sim_twi_bus_monitor.sv
`timescale 1ns/1ps
module sim_twi_bus_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic       evt_valid;
  logic [3:0] evt_kind;
  logic [7:0] evt_value;

  always #10 clk = ~clk;

  twi_bus_monitor u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_value(evt_value)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  int got_kind [64];
  int got_val  [64];
  int got_cyc  [64];
  int got_n = 0;
  int exp_kind [64];
  int exp_val  [64];
  int exp_n = 0;

  localparam int H = 4;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (evt_valid && got_n < 64) begin
      got_kind[got_n] = int'(evt_kind);
      got_val[got_n]  = int'(evt_value);
      got_cyc[got_n]  = cyc;
      got_n = got_n + 1;
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_ev(input int k, input int v);
    exp_kind[exp_n] = k;
    exp_val[exp_n]  = v;
    exp_n = exp_n + 1;
  endtask

  task automatic clear_log();
    got_n = 0;
    exp_n = 0;
  endtask

  task automatic compare(input string tag);
    total++;
    if (got_n != exp_n) begin
      bad++;
      $display("FAIL %s event count actual=%0d expected=%0d", tag, got_n, exp_n);
    end
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      total++;
      if (got_kind[i] != exp_kind[i] || got_val[i] != exp_val[i]) begin
        bad++;
        $display("FAIL %s event %0d actual=(%0d,0x%02h) expected=(%0d,0x%02h)",
                 tag, i, got_kind[i], got_val[i], exp_kind[i], exp_val[i]);
      end
      if ((exp_kind[i] == 6 || exp_kind[i] == 7) && i > 0) begin
        total++;
        if (got_cyc[i] != got_cyc[i-1] + 1) begin
          bad++;
          $display("FAIL R4 %s ack spacing actual=%0d expected=1",
                   tag, got_cyc[i] - got_cyc[i-1]);
        end
      end
    end
    clear_log();
  endtask

  task automatic bus_start();
    sda = 1; waitc(H); scl = 1; waitc(H); sda = 0; waitc(H); scl = 0; waitc(H);
  endtask

  task automatic bus_stop();
    sda = 0; waitc(H); scl = 1; waitc(H); sda = 1; waitc(H);
  endtask

  task automatic bus_bit(input logic b);
    scl = 0; sda = b; waitc(H); scl = 1; waitc(2 * H); scl = 0; waitc(H);
  endtask

  task automatic bus_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(ack);
  endtask

  function automatic int addr_kind(input logic [7:0] a);
    return a[0] ? 3 : 2;
  endfunction

  // addr[7:0], data[7:0], ack on address, ack on data
  localparam logic [17:0] VEC [4] = '{
    {8'hA0, 8'h5A, 1'b0, 1'b0},
    {8'h91, 8'hC3, 1'b0, 1'b1},
    {8'h3F, 8'hFF, 1'b1, 1'b1},
    {8'h00, 8'h01, 1'b0, 1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R1: data low, clock high through reset, then released high
    scl = 1; sda = 0;
    waitc(5);
    total++;
    if (evt_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 valid during reset actual=%b expected=0", evt_valid);
    end
    rst = 0;
    waitc(10);
    sda = 1;
    waitc(10);
    compare("R1");

    // R8: clock pulses and a stop while waiting for a start
    bus_bit(1); bus_bit(0); bus_bit(1);
    bus_stop();
    compare("R8");

    // R2 R3 R4 R5 R7: table of simple transactions
    for (int t = 0; t < 4; t++) begin
      logic [7:0] a, d;
      logic aa, da;
      {a, d, aa, da} = VEC[t];
      bus_start();
      bus_byte(a, aa);
      bus_byte(d, da);
      bus_stop();
      expect_ev(0, 0);
      expect_ev(addr_kind(a), int'({a[7:1], 1'b0}));
      expect_ev(aa ? 7 : 6, 0);
      expect_ev(a[0] ? 5 : 4, int'(d));
      expect_ev(da ? 7 : 6, 0);
      expect_ev(8, 0);
      compare($sformatf("R2 R3 R4 R5 R7 vec%0d", t));
    end

    // R6: repeated start switching direction
    bus_start();
    bus_byte(8'h50, 1'b0);
    bus_byte(8'h12, 1'b0);
    bus_start();
    bus_byte(8'h51, 1'b0);
    bus_byte(8'h34, 1'b1);
    bus_stop();
    expect_ev(0, 0);   expect_ev(2, 8'h50); expect_ev(6, 0);
    expect_ev(4, 8'h12); expect_ev(6, 0);
    expect_ev(1, 0);   expect_ev(3, 8'h50); expect_ev(6, 0);
    expect_ev(5, 8'h34); expect_ev(7, 0);
    expect_ev(8, 0);
    compare("R6");

    // R7: start after stop is a first start again
    bus_start();
    bus_byte(8'h22, 1'b0);
    bus_stop();
    expect_ev(0, 0); expect_ev(2, 8'h22); expect_ev(6, 0); expect_ev(8, 0);
    compare("R7");

    // R9: stop and start shapes during address collection are ignored
    bus_start();
    bus_bit(1); bus_bit(0); bus_bit(1);
    scl = 0; sda = 0; waitc(H);
    scl = 1; waitc(H);
    sda = 1; waitc(H);
    sda = 0; waitc(H);
    scl = 0; waitc(H);
    bus_bit(1); bus_bit(1); bus_bit(0); bus_bit(0);
    bus_bit(0);
    bus_stop();
    expect_ev(0, 0); expect_ev(2, 8'hAC); expect_ev(6, 0); expect_ev(8, 0);
    compare("R9");

    // R1: reset in mid-transfer leaves the block waiting for a start
    bus_start();
    bus_bit(1); bus_bit(1);
    rst = 1; waitc(3); rst = 0;
    scl = 1; sda = 1; waitc(10);
    bus_bit(1); bus_bit(0);
    bus_stop();
    expect_ev(0, 0);
    compare("R1 mid-transfer reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule